// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives several pulse-width-modulated outputs from one free-running counter. A dedicated period slot (the last match slot, after the duty slots) sets the cycle length for every output, so all outputs run at one common frequency. Each output channel owns a duty threshold. The output is low while the counter is below that threshold and high from the threshold to the end of the cycle.

Software writes period and duty values through simple write strobes. Each value lands in a shadow register and moves into the active register only when the counter wraps. A running waveform can therefore be retuned without a torn cycle. Each channel can raise a one-cycle interrupt pulse when the counter hits its threshold. A duty write aimed at the period slot is refused and flagged.

Top module: `pwm_match_unit`

## Requirements
- R1: After reset, `count`, `pwm_out`, `irq` and `wr_err` are all zero.
- R2: While `run` is high, `count` advances by one per clock. While `run` is low, `count` holds its value.
- R3: When `count` equals the active period value P, it returns to 0 on the next clock. A full cycle is therefore P+1 clocks, and it is shared by every channel.
- R4: For an enabled channel with active duty D < P, `pwm_out` is 1 in the cycles where `count` >= D and 0 where `count` < D. It is aligned with the `count` value shown in the same cycle.
- R5: A duty of 0 keeps the output high for the whole cycle. A duty of P or above keeps it low for the whole cycle.
- R6: Duty writes (`duty_sel` 0..NUM_CH-1) and period writes go to shadow registers. They become active from the first cycle after `count` equals the active period. The cycle in progress still uses the old values.
- R7: A duty write with `duty_sel` >= NUM_CH (the period slot) is rejected. `wr_err` is 1 for exactly the next cycle, and no duty or period value changes.
- R8: When a channel's `pwm_en` bit is 0, its output is 0 from the next clock onward, whatever the counter and duty values are.
- R9: With `irq_en`, `pwm_en` and `run` high and D < P, `irq` for that channel pulses for one cycle. The pulse appears in the cycle after `count` equals D, that is, when `count` shows D+1. No pulse occurs when D >= P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter enable |
| per_wr | input | 1 | Write strobe for the period shadow register |
| per_data | input | CNT_W | Period value P |
| duty_wr | input | 1 | Write strobe for a duty shadow register |
| duty_sel | input | SEL_W | Target slot of the duty write (NUM_CH is the period slot and is rejected) |
| duty_data | input | CNT_W | Duty threshold |
| pwm_en | input | NUM_CH | Per-channel output enable |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| count | output | CNT_W | Current counter value |
| pwm_out | output | NUM_CH | PWM outputs |
| irq | output | NUM_CH | Per-channel threshold-hit pulses |
| wr_err | output | 1 | One-cycle pulse for a rejected duty write |

## Verification
Every output is registered from next-state values, so `pwm_out` lines up with the `count` value shown in the same cycle. `irq` lags the threshold hit by one clock. `wr_err` and enable changes take effect one clock after the strobe. Shadowed values apply from the cycle after `count` showed P. The bench samples on the falling edge and keys each expectation to the observed `count` value, never to a guessed absolute cycle. Writes are placed away from the wrap cycle, so every check has only one correct answer.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  // Classification of a duty-port write
  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_DUTY   = 2'd1,
    WK_REJECT = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] per_nxt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] per_sh_q, per_sh_nxt;

  always_comb begin
    wrap       = run && (cnt_q == per_q);
    cnt_nxt    = cnt_q;
    if (run) cnt_nxt = wrap ? ZERO : cnt_q + ONE;
    per_sh_nxt = per_wr ? per_data : per_sh_q;
    per_nxt    = wrap ? per_sh_q : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      per_q    <= '0;
      per_sh_q <= '0;
    end else begin
      cnt_q    <= cnt_nxt;
      per_q    <= per_nxt;
      per_sh_q <= per_sh_nxt;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == per_q) |=> (cnt_q == '0)); // R3
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q)); // R2
  AST_PERIOD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && cnt_q == per_q) |=> $stable(per_q)); // R6
endmodule

// File: rtl/pwm_wr_decode.sv
`timescale 1ns/1ps
module pwm_wr_decode
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              duty_wr,
  input  logic [SEL_W-1:0]  duty_sel,
  output logic [NUM_CH-1:0] ch_wr,
  output logic              wr_err
);
  localparam logic [SEL_W-1:0] PER_SLOT = SEL_W'(NUM_CH);

  wr_kind_e kind;
  logic     err_nxt;

  always_comb begin
    kind = WK_NONE;
    if (duty_wr) kind = (duty_sel >= PER_SLOT) ? WK_REJECT : WK_DUTY;
    err_nxt = (kind == WK_REJECT);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_wr[i] = (kind == WK_DUTY) && (duty_sel == SEL_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= err_nxt;
  end

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_wr && duty_sel >= PER_SLOT) |=> wr_err); // R7
  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_sel >= PER_SLOT) |-> (ch_wr == '0)); // R7
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr)); // R6
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] per_q,
  input  logic [CNT_W-1:0] per_nxt,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             en,
  input  logic             irq_en,
  output logic             pwm,
  output logic             irq
);
  logic [CNT_W-1:0] duty_sh_q, duty_sh_nxt;
  logic [CNT_W-1:0] duty_q, duty_nxt;
  logic             pwm_nxt, irq_nxt;

  always_comb begin
    duty_sh_nxt = wr ? wr_data : duty_sh_q;
    duty_nxt    = wrap ? duty_sh_q : duty_q;
    // level for the cycle that starts at the coming edge
    pwm_nxt     = en && (duty_nxt < per_nxt) && (cnt_nxt >= duty_nxt);
    // threshold hit in the current cycle
    irq_nxt     = run && en && irq_en && (duty_q < per_q) && (cnt_q == duty_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_sh_q <= '0;
      duty_q    <= '0;
      pwm       <= 1'b0;
      irq       <= 1'b0;
    end else begin
      duty_sh_q <= duty_sh_nxt;
      duty_q    <= duty_nxt;
      pwm       <= pwm_nxt;
      irq       <= irq_nxt;
    end
  end

  AST_HIGH_ONLY_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    pwm |-> (cnt_q >= duty_q)); // R4
  AST_DUTY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_q)); // R6
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
endmodule

// File: rtl/pwm_match_unit.sv
`timescale 1ns/1ps
module pwm_match_unit #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  parameter int SEL_W  = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              per_wr,
  input  logic [CNT_W-1:0]  per_data,
  input  logic              duty_wr,
  input  logic [SEL_W-1:0]  duty_sel,
  input  logic [CNT_W-1:0]  duty_data,
  input  logic [NUM_CH-1:0] pwm_en,
  input  logic [NUM_CH-1:0] irq_en,
  output logic [CNT_W-1:0]  count,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] irq,
  output logic              wr_err
);
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, per_q, per_nxt;
  logic              wrap;
  logic [NUM_CH-1:0] ch_wr;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run),
    .per_wr(per_wr), .per_data(per_data),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .per_q(per_q), .per_nxt(per_nxt), .wrap(wrap)
  );

  pwm_wr_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .duty_wr(duty_wr), .duty_sel(duty_sel),
    .ch_wr(ch_wr), .wr_err(wr_err)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap),
      .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .per_q(per_q), .per_nxt(per_nxt),
      .wr(ch_wr[i]), .wr_data(duty_data),
      .en(pwm_en[i]), .irq_en(irq_en[i]),
      .pwm(pwm_out[i]), .irq(irq[i])
    );
  end

  assign count = cnt_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (count == '0 && pwm_out == '0 && irq == '0)); // R1
endmodule

// File: tb/tb_pwm_match_unit.sv
`timescale 1ns/1ps
module tb_pwm_match_unit;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 3;
  localparam int SEL_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              run;
  logic              per_wr;
  logic [CNT_W-1:0]  per_data;
  logic              duty_wr;
  logic [SEL_W-1:0]  duty_sel;
  logic [CNT_W-1:0]  duty_data;
  logic [NUM_CH-1:0] pwm_en;
  logic [NUM_CH-1:0] irq_en;
  logic [CNT_W-1:0]  count;
  logic [NUM_CH-1:0] pwm_out;
  logic [NUM_CH-1:0] irq;
  logic              wr_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  pwm_match_unit #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .per_wr(per_wr), .per_data(per_data),
    .duty_wr(duty_wr), .duty_sel(duty_sel), .duty_data(duty_data),
    .pwm_en(pwm_en), .irq_en(irq_en),
    .count(count), .pwm_out(pwm_out), .irq(irq), .wr_err(wr_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance at least one cycle, then until count shows v
  task automatic wait_count(input int v, input string req);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (count != CNT_W'(v) && k < 200);
    chk(req, "count reached", 32'(count), 32'(v));
  endtask

  task automatic wr_duty(input int sel, input int val);
    duty_wr = 1'b1; duty_sel = SEL_W'(sel); duty_data = CNT_W'(val);
    @(negedge clk);
    duty_wr = 1'b0;
  endtask

  task automatic wr_per(input int val);
    per_wr = 1'b1; per_data = CNT_W'(val);
    @(negedge clk);
    per_wr = 1'b0;
  endtask

  // one full cycle from count 0: levels (R4/R5/R8), interrupts (R9), length (R3)
  task automatic check_cycle(input int p, input int d0, input int d1, input int d2,
                             input string req);
    int d[3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    wait_count(0, req);
    for (int k = 0; k <= p; k++) begin
      chk(req, "count step", 32'(count), 32'(k));
      for (int i = 0; i < NUM_CH; i++) begin
        logic e_pwm, e_irq;
        e_pwm = pwm_en[i] && (d[i] < p) && (k >= d[i]);
        e_irq = pwm_en[i] && irq_en[i] && (d[i] < p) && (k == d[i] + 1);
        chk(req, $sformatf("pwm_out[%0d] at count %0d", i, k), 32'(pwm_out[i]), 32'(e_pwm));
        chk("R9", $sformatf("irq[%0d] at count %0d", i, k), 32'(irq[i]), 32'(e_irq));
      end
      @(negedge clk);
    end
    chk("R3", "wrap after P+1 cycles", 32'(count), 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; run = 1'b0; per_wr = 1'b0; per_data = '0;
    duty_wr = 1'b0; duty_sel = '0; duty_data = '0; pwm_en = '0; irq_en = '0;
    repeat (3) @(negedge clk);
    chk("R1", "count", 32'(count), 0);
    chk("R1", "pwm_out", 32'(pwm_out), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "wr_err", 32'(wr_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic;
    wr_per(9);
    wr_duty(0, 3);
    wr_duty(1, 0);
    wr_duty(2, 10);
    pwm_en = 3'b111;
    run = 1'b1;
    wait_count(4, "R2");
    @(negedge clk);
    chk("R2", "increment", 32'(count), 5);
    check_cycle(9, 3, 0, 10, "R4");
  endtask

  task automatic t_exact_period_duty;
    wait_count(1, "R5");
    wr_duty(2, 9);
    check_cycle(9, 3, 0, 9, "R5");
  endtask

  task automatic t_live_update;
    wait_count(5, "R6");
    wr_duty(0, 7);
    chk("R6", "old duty kept mid-cycle", 32'(pwm_out[0]), 1);
    wait_count(9, "R6");
    chk("R6", "old duty at period end", 32'(pwm_out[0]), 1);
    @(negedge clk);
    chk("R6", "new duty at cycle start", 32'(pwm_out[0]), 0);
    check_cycle(9, 7, 0, 9, "R6");
  endtask

  task automatic t_reject;
    wait_count(1, "R7");
    wr_duty(3, 2);
    chk("R7", "wr_err pulse", 32'(wr_err), 1);
    @(negedge clk);
    chk("R7", "wr_err clears", 32'(wr_err), 0);
    check_cycle(9, 7, 0, 9, "R7");
  endtask

  task automatic t_enable;
    pwm_en = 3'b110;
    @(negedge clk);
    chk("R8", "disabled output low", 32'(pwm_out[0]), 0);
    check_cycle(9, 7, 0, 9, "R8");
    pwm_en = 3'b111;
  endtask

  task automatic t_irq;
    irq_en = 3'b101;
    check_cycle(9, 7, 0, 9, "R9");
    irq_en = 3'b011;
    check_cycle(9, 7, 0, 9, "R9");
    irq_en = 3'b000;
  endtask

  task automatic t_period_change;
    wait_count(2, "R6");
    wr_per(4);
    wait_count(9, "R6");
    wait_count(1, "R6");
    wr_duty(0, 2);
    check_cycle(4, 2, 0, 9, "R3");
  endtask

  task automatic t_idle;
    logic [CNT_W-1:0] held;
    wait_count(3, "R2");
    held = count;
    run = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R2", "count holds while idle", 32'(count), 32'(held));
    end
    run = 1'b1;
    @(negedge clk);
    chk("R2", "count resumes", 32'(count), 32'(held) + 1);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_basic;
    t_exact_period_duty;
    t_live_update;
    t_reject;
    t_enable;
    t_irq;
    t_period_change;
    t_idle;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule